// File: doc/BRIEF.md
# Snooping Cache Line Coherence Controller

This block holds the coherence state of one line in a write-back cache that sits on a shared snooping bus. A build-time parameter chooses among three protocols: three-state MSI, four-state MESI and five-state MOESI. The MOESI variant adds an owned state, so dirty data can be shared without a write to memory. Processor reads and writes are served at once when the local state allows them. Otherwise the block raises a bus request carrying the right command and stalls the processor until the bus completion pulse.

Transactions from other caches are snooped. The block reacts in the same cycle by driving one of two outputs: a write-back to memory or a cache-to-cache data supply. The state update follows at the next clock edge. A shared-line input, sampled at completion, tells a MESI or MOESI read fill whether another cache already holds the block.

Top module: `snoop_coh_line`

## Requirements
- R1: After reset the line state is Invalid (0), no bus request is raised and neither flush output is active. State codes: Invalid 0, Shared 1, Exclusive 2, Owned 3, Modified 4.
- R2: A read to any valid state, and a write to Modified, are acknowledged in the same cycle without a bus request, and the state is kept.
- R3: A read to an Invalid line raises a bus request with command 0 (read) and stalls. The state changes on the bus_done cycle, when the request is acknowledged. MSI fills to Shared. MESI and MOESI fill to Exclusive when bus_shared is 0 and to Shared when it is 1.
- R4: A write to a Shared or Owned line requests command 2 (upgrade). A write to an Invalid line requests command 1 (read-exclusive). On bus_done the write is acknowledged and the line becomes Modified.
- R5: A write to an Exclusive line is acknowledged at once without a bus request, and the line becomes Modified.
- R6: A Modified line snooping a read (snoop code 0) behaves as follows. In MSI and MESI it drives flush_mem and moves to Shared. In MOESI it drives flush_c2c and moves to Owned.
- R7: An Owned line behaves as follows. On a snooped read it drives flush_c2c and stays Owned. On a read-exclusive (code 1) it drives flush_c2c and becomes Invalid. On an upgrade (code 2) it drives no flush and becomes Invalid. A Modified line snooping a read-exclusive becomes Invalid, driving flush_mem in MSI and MESI and flush_c2c in MOESI.
- R8: A Shared or Exclusive line drives no flush output. It becomes Invalid on a snooped read-exclusive or upgrade. An Exclusive line becomes Shared on a snooped read.
- R9: An Invalid line stays Invalid and drives no flush under every snoop code. Snooped memory flush (code 3) and cache-to-cache flush (code 4) leave every state unchanged.
- R10: In a cycle with snp_valid high, the processor is not acknowledged and stays stalled. A pending write whose line is invalidated by the snoop switches its bus command from upgrade to read-exclusive.
- R11: With MSI selected, the state never takes the Exclusive code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd | input | 1 | Processor read request, held until acknowledged |
| cpu_wr | input | 1 | Processor write request, held until acknowledged; has priority over cpu_rd |
| cpu_ack | output | 1 | Request served this cycle |
| cpu_stall | output | 1 | Request present but not served |
| bus_req | output | 1 | Bus transaction needed |
| bus_cmd | output | 2 | 0 read, 1 read-exclusive, 2 upgrade |
| bus_done | input | 1 | Own bus transaction completes this cycle |
| bus_shared | input | 1 | Another cache holds the line (sampled with bus_done) |
| snp_valid | input | 1 | Snooped transaction for this line |
| snp_cmd | input | 3 | 0 read, 1 read-exclusive, 2 upgrade, 3 memory flush, 4 cache-to-cache flush |
| flush_mem | output | 1 | Write dirty data back to memory in response to the snoop |
| flush_c2c | output | 1 | Supply data to the requesting cache |
| line_state | output | 3 | Current coherence state |

## Verification
A snoop and a processor request can land in the same cycle. This happens either with a hit that the line could otherwise serve at once, or with a request that is waiting on the bus. The bench provokes both by holding a read on Shared and Owned lines while a snooped read arrives, and by holding a write that waits for an upgrade while a snooped read-exclusive invalidates the line. It judges the collision in three ways: the acknowledge is withheld in that cycle, the flush response and the new state follow the snoop alone, and the waiting write's command changes from upgrade to read-exclusive in the next cycle.

// File: rtl/snoop_coh_line.sv
module snoop_coh_line #(
  parameter int PROTO = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_rd,
  input  logic       cpu_wr,
  output logic       cpu_ack,
  output logic       cpu_stall,
  output logic       bus_req,
  output logic [1:0] bus_cmd,
  input  logic       bus_done,
  input  logic       bus_shared,
  input  logic       snp_valid,
  input  logic [2:0] snp_cmd,
  output logic       flush_mem,
  output logic       flush_c2c,
  output logic [2:0] line_state
);
  localparam logic [2:0] ST_I = 3'd0, ST_S = 3'd1, ST_E = 3'd2, ST_O = 3'd3, ST_M = 3'd4;
  localparam logic [1:0] CMD_RD = 2'd0, CMD_RDX = 2'd1, CMD_UPG = 2'd2;
  localparam bit HAS_E = (PROTO != 0);
  localparam bit HAS_O = (PROTO == 2);

  logic [2:0] st, nxt, snp_nxt;
  logic       req, hit, sn_rd, sn_rdx, sn_upg, fm, fc;

  assign req     = cpu_rd | cpu_wr;
  assign hit     = cpu_wr ? (st == ST_M || st == ST_E) : (st != ST_I);
  assign bus_req = req && !hit;
  assign bus_cmd = !cpu_wr ? CMD_RD : (st == ST_I ? CMD_RDX : CMD_UPG);
  assign cpu_ack   = req && !snp_valid && (hit || bus_done);
  assign cpu_stall = req && !cpu_ack;

  assign sn_rd  = (snp_cmd == 3'd0);
  assign sn_rdx = (snp_cmd == 3'd1);
  assign sn_upg = (snp_cmd == 3'd2);

  always_comb begin
    snp_nxt = st;
    fm = 1'b0;
    fc = 1'b0;
    case (st)
      ST_M: begin
        if (sn_rd) begin
          if (HAS_O) begin fc = 1'b1; snp_nxt = ST_O; end
          else       begin fm = 1'b1; snp_nxt = ST_S; end
        end else if (sn_rdx || sn_upg) begin
          if (HAS_O) fc = 1'b1;
          else       fm = 1'b1;
          snp_nxt = ST_I;
        end
      end
      ST_O: begin
        if (sn_rd)       fc = 1'b1;
        else if (sn_rdx) begin fc = 1'b1; snp_nxt = ST_I; end
        else if (sn_upg) snp_nxt = ST_I;
      end
      ST_S, ST_E: begin
        if (sn_rd)                 snp_nxt = ST_S;
        else if (sn_rdx || sn_upg) snp_nxt = ST_I;
      end
      default: snp_nxt = st;
    endcase
  end

  assign flush_mem = snp_valid && fm;
  assign flush_c2c = snp_valid && fc;

  always_comb begin
    nxt = st;
    if (snp_valid)        nxt = snp_nxt;
    else if (cpu_ack) begin
      if (cpu_wr)         nxt = ST_M;
      else if (st == ST_I) nxt = (HAS_E && !bus_shared) ? ST_E : ST_S;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_I;
    else        st <= nxt;
  end

  assign line_state = st;

  a_r4_write_done_mod: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack && cpu_wr |=> line_state == ST_M);
  a_r5_excl_write: assert property (@(posedge clk) disable iff (!rst_n)
    line_state == ST_E && cpu_wr && !snp_valid |=> line_state == ST_M && !$past(bus_req));
  a_r6_mod_snoop_rd: assert property (@(posedge clk) disable iff (!rst_n)
    line_state == ST_M && snp_valid && snp_cmd == 3'd0 |=> line_state == (HAS_O ? ST_O : ST_S));
  a_r8_snoop_inval: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && (snp_cmd == 3'd1 || snp_cmd == 3'd2) |=> line_state == ST_I);
  a_r9_inv_holds: assert property (@(posedge clk) disable iff (!rst_n)
    line_state == ST_I && snp_valid |=> line_state == ST_I);
  a_r10_one_flush: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flush_mem, flush_c2c}));

  always @(posedge clk)
    if (rst_n && PROTO == 0) a_r11_no_excl_msi: assert (line_state != ST_E);
endmodule

// File: tb/snoop_coh_line_tb.sv
module snoop_coh_line_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_rd = 0, cpu_wr = 0, bus_done = 0, bus_shared = 0, snp_valid = 0;
  logic [2:0] snp_cmd = 0;
  logic [2:0] ack, stall, breq, fm, fc;
  logic [1:0] cmd [0:2];
  logic [2:0] st  [0:2];
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  snoop_coh_line #(.PROTO(0)) u_msi (.clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_ack(ack[0]), .cpu_stall(stall[0]), .bus_req(breq[0]), .bus_cmd(cmd[0]), .bus_done(bus_done),
    .bus_shared(bus_shared), .snp_valid(snp_valid), .snp_cmd(snp_cmd), .flush_mem(fm[0]),
    .flush_c2c(fc[0]), .line_state(st[0]));
  snoop_coh_line #(.PROTO(1)) u_mesi (.clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_ack(ack[1]), .cpu_stall(stall[1]), .bus_req(breq[1]), .bus_cmd(cmd[1]), .bus_done(bus_done),
    .bus_shared(bus_shared), .snp_valid(snp_valid), .snp_cmd(snp_cmd), .flush_mem(fm[1]),
    .flush_c2c(fc[1]), .line_state(st[1]));
  snoop_coh_line #(.PROTO(2)) u_dut (.clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_ack(ack[2]), .cpu_stall(stall[2]), .bus_req(breq[2]), .bus_cmd(cmd[2]), .bus_done(bus_done),
    .bus_shared(bus_shared), .snp_valid(snp_valid), .snp_cmd(snp_cmd), .flush_mem(fm[2]),
    .flush_c2c(fc[2]), .line_state(st[2]));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_st(string tag, int e0, int e1, int e2);
    chk({tag, " msi state"}, st[0], e0);
    chk({tag, " mesi state"}, st[1], e1);
    chk({tag, " moesi state"}, st[2], e2);
  endtask

  task automatic drive(bit rd, bit wr, bit sv, int sc, bit dn, bit sh);
    @(negedge clk);
    cpu_rd = rd; cpu_wr = wr; snp_valid = sv; snp_cmd = 3'(sc); bus_done = dn; bus_shared = sh;
    #1;
  endtask

  task automatic fin;
    @(posedge clk); #1;
    cpu_rd = 0; cpu_wr = 0; snp_valid = 0; snp_cmd = 0; bus_done = 0; bus_shared = 0;
  endtask

  task automatic t_reset;
    chk_st("R1 reset", 0, 0, 0);
    chk("R1 bus_req", breq, 0);
    chk("R1 flushes", {fm, fc}, 0);
  endtask

  task automatic t_read_miss_excl;
    drive(1, 0, 0, 0, 0, 0);
    chk("R3 read miss req", breq, 3'b111);
    chk("R3 read cmd", cmd[2], 0);
    chk("R3 stall", stall, 3'b111);
    fin;
    chk_st("R3 waiting", 0, 0, 0);
    drive(1, 0, 0, 0, 1, 0);
    chk("R3 ack on done", ack, 3'b111);
    fin;
    chk_st("R3 fill unshared", 1, 2, 2);
  endtask

  task automatic t_write_upgrade_and_excl;
    drive(0, 1, 0, 0, 0, 0);
    chk("R4 msi upgrade cmd", cmd[0], 2);
    chk("R5 excl write ack no bus", {ack, breq}, {3'b110, 3'b001});
    fin;
    chk_st("R5 excl to mod", 1, 4, 4);
    drive(0, 1, 0, 0, 1, 0);
    chk("R4 ack", ack, 3'b111);
    fin;
    chk_st("R4 upgrade done", 4, 4, 4);
  endtask

  task automatic t_mod_hits;
    drive(1, 0, 0, 0, 0, 0);
    chk("R2 read hit", {ack, breq}, {3'b111, 3'b000});
    fin;
    drive(0, 1, 0, 0, 0, 0);
    chk("R2 write hit", {ack, breq}, {3'b111, 3'b000});
    fin;
    chk_st("R2 stays mod", 4, 4, 4);
  endtask

  task automatic t_mod_snoop_read;
    drive(0, 0, 1, 0, 0, 0);
    chk("R6 flush_mem", fm, 3'b011);
    chk("R6 flush_c2c", fc, 3'b100);
    fin;
    chk_st("R6 after snoop read", 1, 1, 3);
  endtask

  task automatic t_collision_hit;
    drive(1, 0, 1, 0, 0, 0);
    chk("R10 ack withheld", ack, 0);
    chk("R10 stall", stall, 3'b111);
    chk("R7 owner supplies", fc, 3'b100);
    chk("R8 shared no flush", fm, 0);
    fin;
    chk_st("R7 owned stays", 1, 1, 3);
    drive(1, 0, 0, 0, 0, 0);
    chk("R2 read hit after snoop", ack, 3'b111);
    fin;
  endtask

  task automatic t_collision_pending;
    drive(0, 1, 0, 0, 0, 0);
    chk("R4 upgrade cmd S/O", {cmd[0], cmd[1], cmd[2]}, 6'b101010);
    fin;
    drive(0, 1, 1, 1, 0, 0);
    chk("R10 ack withheld", ack, 0);
    chk("R7 owner rdx supplies", fc, 3'b100);
    fin;
    chk_st("R10 invalidated", 0, 0, 0);
    drive(0, 1, 0, 0, 0, 0);
    chk("R10 cmd now rdx", {cmd[0], cmd[1], cmd[2]}, 6'b010101);
    fin;
    drive(0, 1, 0, 0, 1, 0);
    chk("R4 rdx ack", ack, 3'b111);
    fin;
    chk_st("R4 rdx to mod", 4, 4, 4);
  endtask

  task automatic t_owned_upgrade;
    drive(0, 0, 1, 0, 0, 0);
    fin;
    chk_st("R6 setup", 1, 1, 3);
    drive(0, 0, 1, 2, 0, 0);
    chk("R7 upgrade no flush", {fm, fc}, 0);
    fin;
    chk_st("R7 R8 upgrade inval", 0, 0, 0);
  endtask

  task automatic t_invalid_snoops;
    for (int c = 0; c < 5; c++) begin
      drive(0, 0, 1, c, 0, 0);
      chk("R9 no flush from I", {fm, fc}, 0);
      fin;
      chk_st("R9 I holds", 0, 0, 0);
    end
  endtask

  task automatic t_shared_fill_and_flush_snoops;
    drive(1, 0, 0, 0, 1, 1);
    chk("R3 ack shared fill", ack, 3'b111);
    fin;
    chk_st("R3 fill shared", 1, 1, 1);
    drive(0, 0, 1, 3, 0, 0);
    fin;
    chk_st("R9 mem flush no change", 1, 1, 1);
    drive(0, 0, 1, 4, 0, 0);
    chk("R8 no flush from S", {fm, fc}, 0);
    fin;
    chk_st("R9 c2c flush no change", 1, 1, 1);
  endtask

  task automatic t_mod_snoop_rdx;
    drive(0, 1, 0, 0, 1, 0);
    fin;
    chk_st("R4 setup", 4, 4, 4);
    drive(0, 0, 1, 1, 0, 0);
    chk("R7 mod rdx flush_mem", fm, 3'b011);
    chk("R7 mod rdx flush_c2c", fc, 3'b100);
    fin;
    chk_st("R7 mod rdx inval", 0, 0, 0);
  endtask

  task automatic t_exclusive_snoops;
    drive(1, 0, 0, 0, 1, 0);
    fin;
    chk_st("R11 msi never excl", 1, 2, 2);
    drive(0, 0, 1, 0, 0, 0);
    chk("R8 excl no flush", {fm, fc}, 0);
    fin;
    chk_st("R8 excl snoop read", 1, 1, 1);
    drive(0, 0, 1, 1, 0, 0);
    fin;
    drive(1, 0, 0, 0, 1, 0);
    fin;
    chk_st("R3 refill", 1, 2, 2);
    drive(0, 0, 1, 2, 0, 0);
    fin;
    chk_st("R8 excl upgrade inval", 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_read_miss_excl;
    t_write_upgrade_and_excl;
    t_mod_hits;
    t_mod_snoop_read;
    t_collision_hit;
    t_collision_pending;
    t_owned_upgrade;
    t_invalid_snoops;
    t_shared_fill_and_flush_snoops;
    t_mod_snoop_rdx;
    t_exclusive_snoops;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule